// File: doc/BRIEF.md
# Clocked Host Controller for an Asynchronous Byte-Lane Static RAM

This block sits between a synchronous host and an external asynchronous static RAM that holds 32,768 words of 16 bits, split into two byte lanes. The host gives it a single-cycle request: a read or write flag, a word address, write data and an active-high byte mask. The controller turns that request into a timed sequence on the memory pins. The memory pins are an address bus, an active-high chip select, active-low write, output and per-lane byte strobes, and a data bus split into out, drive-enable and in. Every strobe is held for a whole number of clock cycles. Each count is worked out at elaboration from a nanosecond timing parameter and the clock-period parameter.

A request is taken when `req_valid` and `req_ready` are both high. `req_ready` then stays low until the access has fully completed. A read returns its data together with a one-cycle `rsp_valid` pulse. Between accesses, chip select is low so the memory sits in standby. After a read, the controller does not drive the data bus until the memory's output has had time to float.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During and after reset, and whenever no access is in progress: `mem_ce` is 0, `mem_we_n`, `mem_oe_n` and every bit of `mem_be_n` are 1, `mem_dq_oe` is 0, and `req_ready` is 1.
- R2: `req_mask` bit 0 selects data bits 7:0 and bit 1 selects bits 15:8. A masked-in lane has its `mem_be_n` bit driven to 0 during the strobe. A write changes only the masked-in lanes, and a write with mask 00 leaves the word unchanged.
- R3: A write holds `mem_we_n` low for WLOW cycles, where WLOW is the largest of the converted write-pulse, data-setup and byte-enable-to-end times. `mem_oe_n` stays 1 throughout the write. `mem_dq_oe` is 1 exactly while `mem_we_n` is 0, and `mem_dq_out` holds steady during that time.
- R4: After `mem_we_n` rises, `mem_ce` stays high for WREC = max(1, WC - WLOW) further cycles and then falls.
- R5: A read holds `mem_oe_n` low, with `mem_ce` high, for RD cycles. RD is the largest of the converted read-cycle, address-access and output-enable-access times. The data bus is sampled on the edge that ends this window, and `rsp_valid` is high for exactly one cycle, the cycle after that edge.
- R6: In `rsp_rdata`, each lane that was masked out of the read is returned as zero.
- R7: After a read, `mem_dq_oe` does not rise until `mem_oe_n` has been high for HZ cycles. A write taken before then keeps `mem_ce` high with all strobes inactive until the gap has passed.
- R8: `req_ready` drops on the accepting edge and stays low until the access completes. A request raised while `req_ready` is low has no effect.
- R9: Each cycle count is the ceiling of the nanosecond value divided by the clock period, with a minimum of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Active-high byte-lane mask |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | 15 | Memory address |
| mem_ce | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte-lane enables, active low |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data from memory |

## Verification
The bench builds the controller with a 10 ns period and raises three of the timing values: write-cycle time 25 ns, data setup 16 ns and bus float 25 ns. This gives a two-cycle write strobe, a one-cycle recovery, a two-cycle read window and a three-cycle turnaround. With the default values every count collapses to one or two cycles, and a read followed by a write would never wait. The raised values make the wait state, the ceiling rounding and the recovery counter all observable at the pins.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WWAIT,
    ST_WLOW,
    ST_WREC,
    ST_RD
  } seq_st_t;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/sram_turn_guard.sv
module sram_turn_guard #(
  parameter int unsigned HZ_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_end,
  output logic bus_free
);
  localparam int CNT_W = $clog2(HZ_CYC + 1);

  logic [CNT_W-1:0] remain;

  // loaded on the edge that raises output enable, counts down to zero
  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (rd_end) begin
      remain <= CNT_W'(HZ_CYC);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  // a drive starting at the coming edge is HZ_CYC cycles past the read end
  assign bus_free = (remain <= CNT_W'(1));

endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sample,
  input  logic [LANES-1:0]         be_n,
  input  logic [LANES*LANE_W-1:0]  dq_in,
  output logic                     rsp_valid,
  output logic [LANES*LANE_W-1:0]  rsp_rdata
);

  always_ff @(posedge clk) begin
    if (rst) rsp_valid <= 1'b0;
    else     rsp_valid <= sample;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        rsp_rdata[g*LANE_W +: LANE_W] <= '0;
      end else if (sample) begin
        rsp_rdata[g*LANE_W +: LANE_W] <= be_n[g] ? '0 : dq_in[g*LANE_W +: LANE_W];
      end
    end
  end

endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
  import sram_ctrl_pkg::*;
#(
  parameter int          ADDR_W   = 15,
  parameter int          LANES    = 2,
  parameter int          LANE_W   = 8,
  parameter int unsigned WLOW_CYC = 1,
  parameter int unsigned WREC_CYC = 1,
  parameter int unsigned RD_CYC   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [LANES*LANE_W-1:0]  req_wdata,
  input  logic [LANES-1:0]         req_mask,
  input  logic                     bus_free,
  output logic                     req_ready,
  output logic                     rd_last,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic                     mem_ce,
  output logic                     mem_we_n,
  output logic                     mem_oe_n,
  output logic [LANES-1:0]         mem_be_n,
  output logic [LANES*LANE_W-1:0]  mem_dq_out,
  output logic                     mem_dq_oe
);
  localparam int unsigned MAXC  = max3(WLOW_CYC, WREC_CYC, RD_CYC);
  localparam int          CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);

  seq_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic [LANES-1:0] lat_be_n;
  logic             accept;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && (st == ST_IDLE);
  assign rd_last   = (st == ST_RD) && (cnt == CNT_W'(RD_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      lat_be_n   <= '1;
      mem_addr   <= '0;
      mem_ce     <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_be_n   <= '1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (accept) begin
            mem_addr <= req_addr;
            mem_ce   <= 1'b1;
            lat_be_n <= ~req_mask;
            if (req_write) begin
              mem_dq_out <= req_wdata;
              if (bus_free) begin
                st        <= ST_WLOW;
                mem_we_n  <= 1'b0;
                mem_be_n  <= ~req_mask;
                mem_dq_oe <= 1'b1;
              end else begin
                st <= ST_WWAIT;
              end
            end else begin
              st       <= ST_RD;
              mem_oe_n <= 1'b0;
              mem_be_n <= ~req_mask;
            end
          end
        end
        ST_WWAIT: begin
          if (bus_free) begin
            st        <= ST_WLOW;
            cnt       <= '0;
            mem_we_n  <= 1'b0;
            mem_be_n  <= lat_be_n;
            mem_dq_oe <= 1'b1;
          end
        end
        ST_WLOW: begin
          if (cnt == CNT_W'(WLOW_CYC - 1)) begin
            st        <= ST_WREC;
            cnt       <= '0;
            mem_we_n  <= 1'b1;
            mem_be_n  <= '1;
            mem_dq_oe <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WREC: begin
          if (cnt == CNT_W'(WREC_CYC - 1)) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            mem_ce <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RD: begin
          if (rd_last) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            mem_oe_n <= 1'b1;
            mem_be_n <= '1;
            mem_ce   <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  wr_oe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n && mem_ce);

  // R2
  be_only_selected_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_ce |-> (&mem_be_n));

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int          ADDR_W    = 15,
  parameter int          LANES     = 2,
  parameter int          LANE_W    = 8,
  parameter int unsigned CLK_NS    = 10,
  parameter int unsigned T_RC_NS   = 12,
  parameter int unsigned T_AA_NS   = 12,
  parameter int unsigned T_DOE_NS  = 6,
  parameter int unsigned T_WC_NS   = 12,
  parameter int unsigned T_PWE_NS  = 8,
  parameter int unsigned T_SD_NS   = 6,
  parameter int unsigned T_BW_NS   = 8,
  parameter int unsigned T_HZ_NS   = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [LANES*LANE_W-1:0]  req_wdata,
  input  logic [LANES-1:0]         req_mask,
  output logic                     rsp_valid,
  output logic [LANES*LANE_W-1:0]  rsp_rdata,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic                     mem_ce,
  output logic                     mem_we_n,
  output logic                     mem_oe_n,
  output logic [LANES-1:0]         mem_be_n,
  output logic [LANES*LANE_W-1:0]  mem_dq_out,
  output logic                     mem_dq_oe,
  input  logic [LANES*LANE_W-1:0]  mem_dq_in
);
  // R9: every strobe length derived from nanoseconds by ceiling division
  localparam int unsigned WLOW_CYC = max3(ns2cyc(T_PWE_NS, CLK_NS), ns2cyc(T_SD_NS, CLK_NS),
                                          ns2cyc(T_BW_NS, CLK_NS));
  localparam int unsigned WC_CYC   = ns2cyc(T_WC_NS, CLK_NS);
  localparam int unsigned WREC_CYC = (WC_CYC > WLOW_CYC + 1) ? (WC_CYC - WLOW_CYC) : 1;
  localparam int unsigned RD_CYC   = max3(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS),
                                          ns2cyc(T_DOE_NS, CLK_NS));
  localparam int unsigned HZ_CYC   = ns2cyc(T_HZ_NS, CLK_NS);

  logic rd_last;
  logic bus_free;

  sram_turn_guard #(.HZ_CYC(HZ_CYC)) u_guard (
    .clk      (clk),
    .rst      (rst),
    .rd_end   (rd_last),
    .bus_free (bus_free)
  );

  sram_phase_seq #(
    .ADDR_W   (ADDR_W),
    .LANES    (LANES),
    .LANE_W   (LANE_W),
    .WLOW_CYC (WLOW_CYC),
    .WREC_CYC (WREC_CYC),
    .RD_CYC   (RD_CYC)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_mask   (req_mask),
    .bus_free   (bus_free),
    .req_ready  (req_ready),
    .rd_last    (rd_last),
    .mem_addr   (mem_addr),
    .mem_ce     (mem_ce),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_be_n   (mem_be_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

  sram_lane_capture #(.LANES(LANES), .LANE_W(LANE_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .sample    (rd_last),
    .be_n      (mem_be_n),
    .dq_in     (mem_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // ---- pin-level watch counters for the timing properties ----
  localparam int HZC_W = $clog2(HZ_CYC + 1);
  localparam int WLC_W = $clog2(WLOW_CYC + 1);

  logic [HZC_W-1:0] oe_hi_cnt;
  logic [WLC_W-1:0] we_lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_hi_cnt <= HZC_W'(HZ_CYC);
      we_lo_cnt <= '0;
    end else begin
      if (!mem_oe_n)                       oe_hi_cnt <= '0;
      else if (oe_hi_cnt < HZC_W'(HZ_CYC)) oe_hi_cnt <= oe_hi_cnt + 1'b1;
      if (mem_we_n)                        we_lo_cnt <= '0;
      else if (we_lo_cnt < WLC_W'(WLOW_CYC)) we_lo_cnt <= we_lo_cnt + 1'b1;
    end
  end

  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe);

  // R3
  drive_with_we_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> !mem_we_n && mem_oe_n);

  // R3
  wdata_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  // R3
  we_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_lo_cnt >= WLC_W'(WLOW_CYC)));

  // R5
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R7
  turnaround_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (oe_hi_cnt >= HZC_W'(HZ_CYC)));

endmodule

// File: tb/sram_strobe_ctrl_tb_top.sv
module sram_strobe_ctrl_tb_top;
  localparam int EXP_WLOW = 2;  // max(8,16,8 ns) over 10 ns
  localparam int EXP_WREC = 1;  // 25 ns -> 3 cycles, minus 2
  localparam int EXP_RD   = 2;  // 12 ns -> 2 cycles
  localparam int EXP_HZ   = 3;  // 25 ns -> 3 cycles

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic        req_valid, req_ready, req_write;
  logic [14:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [14:0] mem_addr;
  logic        mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_out, mem_dq_in;

  sram_strobe_ctrl #(
    .CLK_NS(10), .T_WC_NS(25), .T_SD_NS(16), .T_HZ_NS(25)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce(mem_ce), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] model  [int];
  logic [15:0] shadow [int];
  logic [15:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---- memory model and pin monitor (negedge) ----
  int we_run = 0, oe_run = 0, rec_run = 0, since_oe = 0, last_gap = -1;
  bit in_rec = 0, gap_armed = 0, prev_rsp = 0;

  always @(negedge clk) begin
    logic [15:0] cur;
    logic [15:0] got;
    if (rst) begin
      mem_dq_in = 16'h5A5A;
      we_run = 0; oe_run = 0; in_rec = 0; gap_armed = 0; prev_rsp = 0;
    end else begin
      if (mem_ce && !mem_we_n) begin
        cur = model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : 16'h0;
        for (int l = 0; l < 2; l++)
          if (!mem_be_n[l]) cur[l*8 +: 8] = mem_dq_out[l*8 +: 8];
        model[int'(mem_addr)] = cur;
      end
      // R3: drive only while write strobe low
      check(mem_dq_oe == !mem_we_n, "R3", "drive vs write strobe", {31'd0, mem_dq_oe},
            {31'd0, !mem_we_n});
      // R3/R9: write strobe width
      if (!mem_we_n) we_run++;
      else if (we_run != 0) begin
        check(we_run == EXP_WLOW, "R3/R9", "write strobe cycles", we_run, EXP_WLOW);
        we_run = 0; in_rec = 1; rec_run = 0;
      end
      if (in_rec && mem_ce && mem_we_n) rec_run++;
      if (in_rec && !mem_ce) begin
        check(rec_run == EXP_WREC, "R4", "recovery cycles", rec_run, EXP_WREC);
        in_rec = 0;
      end
      // R5/R9: read window and R7 gap
      if (!mem_oe_n) oe_run++;
      else if (oe_run != 0) begin
        check(oe_run == EXP_RD, "R5/R9", "read window cycles", oe_run, EXP_RD);
        oe_run = 0; gap_armed = 1; since_oe = 1;
      end else begin
        if (mem_dq_oe && gap_armed) begin
          last_gap = since_oe;
          check(since_oe >= EXP_HZ, "R7", "turnaround gap", since_oe, EXP_HZ);
          gap_armed = 0;
        end
        since_oe++;
      end
      // scoreboard monitor
      if (rsp_valid) begin
        check(!prev_rsp, "R5", "response pulse length", 2, 1);
        if (exp_q.size() == 0) check(0, "R5", "unexpected response", rsp_rdata, 0);
        else begin
          got = exp_q.pop_front();
          check(rsp_rdata == got, tag_q.pop_front(), "read data", rsp_rdata, got);
        end
      end
      prev_rsp = rsp_valid;
      cur = model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : 16'h0;
      for (int l = 0; l < 2; l++)
        mem_dq_in[l*8 +: 8] = (mem_ce && !mem_oe_n && mem_we_n && !mem_be_n[l])
                              ? cur[l*8 +: 8] : 8'h5A;
    end
  end

  // ---- driver ----
  task automatic do_req(input bit wr, input int a, input logic [15:0] d,
                        input logic [1:0] m, input string tag);
    logic [15:0] w;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = 15'(a); req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    // R8: not ready right after acceptance
    check(req_ready == 1'b0, "R8", "ready after accept", {31'd0, req_ready}, 0);
    w = shadow.exists(a) ? shadow[a] : 16'h0;
    if (wr) begin
      for (int l = 0; l < 2; l++) if (m[l]) w[l*8 +: 8] = d[l*8 +: 8];
      shadow[a] = w;
    end else begin
      for (int l = 0; l < 2; l++) if (!m[l]) w[l*8 +: 8] = 8'h00;
      exp_q.push_back(w);
      tag_q.push_back(tag);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5", "responses outstanding", exp_q.size(), 0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst = 1; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_mask = '0;
    mem_dq_in = 16'h5A5A;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: standby after reset
    check(!mem_ce && mem_we_n && mem_oe_n && (&mem_be_n) && !mem_dq_oe && req_ready,
          "R1", "standby pins", {26'd0, mem_ce, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe},
          {26'd0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0});

    // boundary addresses, full word (R2, R5)
    do_req(1, 0,       16'h1234, 2'b11, "R2");
    do_req(1, 'h7FFF,  16'hABCD, 2'b11, "R2");
    do_req(0, 0,       16'h0,    2'b11, "R5");
    do_req(0, 'h7FFF,  16'h0,    2'b11, "R5");

    // lane writes (R2)
    do_req(1, 'h10, 16'hFFFF, 2'b11, "R2");
    do_req(1, 'h10, 16'h00AA, 2'b01, "R2");
    do_req(0, 'h10, 16'h0,    2'b11, "R2");
    do_req(1, 'h10, 16'h5500, 2'b10, "R2");
    do_req(0, 'h10, 16'h0,    2'b11, "R2");
    do_req(1, 'h10, 16'h0000, 2'b00, "R2");
    do_req(0, 'h10, 16'h0,    2'b11, "R2");

    // masked-out lanes read as zero (R6)
    do_req(0, 'h10, 16'h0, 2'b01, "R6");
    do_req(0, 'h10, 16'h0, 2'b10, "R6");
    do_req(0, 'h10, 16'h0, 2'b00, "R6");

    // R8: request raised while busy is ignored
    do_req(1, 'h20, 16'h1111, 2'b11, "R8");
    req_valid = 1; req_write = 1; req_addr = 15'h55; req_wdata = 16'hDEAD; req_mask = 2'b11;
    @(negedge clk);
    req_valid = 0;
    check(!model.exists('h55), "R8", "busy request wrote memory", 1, 0);
    do_req(0, 'h55, 16'h0, 2'b11, "R8");

    // R7: write right behind a read waits out the float time
    drain();
    do_req(0, 'h20, 16'h0,    2'b11, "R5");
    do_req(1, 'h21, 16'h7E7E, 2'b11, "R7");
    repeat (6) @(negedge clk);
    check(last_gap == EXP_HZ, "R7", "gap after read then write", last_gap, EXP_HZ);
    do_req(0, 'h21, 16'h0, 2'b11, "R7");

    // back-to-back reads and writes
    do_req(0, 'h7FFF, 16'h0,    2'b11, "R5");
    do_req(0, 0,      16'h0,    2'b10, "R6");
    do_req(1, 'h4000, 16'hC3C3, 2'b11, "R2");
    do_req(1, 'h4000, 16'h0F0F, 2'b10, "R2");
    do_req(0, 'h4000, 16'h0,    2'b11, "R2");
    drain();
    // R1: back to standby
    check(!mem_ce && req_ready, "R1", "standby when idle", {30'd0, mem_ce, req_ready}, 1);
    finish_up();
  end

endmodule